// File: doc/BRIEF.md
# Stop-Mode Wake-Up Stabilization Controller

This block sequences a microcontroller's deepest sleep state. When the CPU requests it, the block stops the main oscillator, gates the internal clock so that RAM, control registers and port registers keep their contents, and drives fixed levels on the crystal pins: the input is forced low and the output is driven high. It then waits for a wake-up event.

An external interrupt wakes the part, but it does not resume at once. The block re-enables the oscillator and keeps the internal clock gated while an 8-bit settle counter counts up from zero to its overflow carry. The counter is clocked by a tap of a free-running divider, and that tap is chosen by a 4-bit prescale code that software loads before the stop request. The codes 0xE and 0xF pick the slowest tap, and so the longest wait. After overflow the clock is released. A two-slot resume window then signals the CPU, and stop requests are ignored during it, so the instruction slots that follow the stop instruction cannot re-enter sleep. A synchronous reset leaves stop or settling directly, without the resume window.

Top module: `stopctl_wake`

## Requirements
- R1: In reset and after it, the block is in the run state: osc_en=1, clk_gate_en=1, xin_force_low=0, xout_force_high=0, cpu_resume=0, in_stop=0.
- R2: A stop_req sampled high in the run state enters stop at that edge. From the next cycle osc_en=0, clk_gate_en=0, xin_force_low=1, xout_force_high=1 and in_stop=1.
- R3: In stop, the outputs hold for as long as ext_irq stays low. stop_req and changes to ckctlr have no effect.
- R4: ext_irq has no effect while the block is running.
- R5: An ext_irq sampled high in stop starts settling. From the next cycle osc_en=1, clk_gate_en=0, both pin forces are 0 and in_stop=1.
- R6: With k = ckctlr[3:1], the settle counter advances once every 2^k cycles from zero and overflows on its 256th advance. clk_gate_en rises exactly 256*2^k+1 clock edges after the edge that sampled ext_irq, counting that edge. The codes 0xE and 0xF both give k=7, the longest wait.
- R7: The prescale code is captured at the edge that accepts stop_req. Later changes to ckctlr do not change the settle length.
- R8: After overflow, the block spends exactly two cycles with clk_gate_en=1, osc_en=1, cpu_resume=1 and in_stop=0, and then returns to the run state with cpu_resume=0.
- R9: stop_req sampled during the two resume cycles is ignored.
- R10: A reset sampled in stop or in settling returns the block to the run state at the next edge, and cpu_resume is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Stop request from the CPU |
| ext_irq | input | 1 | External interrupt wake-up |
| ckctlr | input | 4 | Prescale code; bits 3:1 select the divider tap |
| osc_en | output | 1 | Main oscillator enable |
| clk_gate_en | output | 1 | Internal clock enable |
| xin_force_low | output | 1 | Forces the crystal input pin low |
| xout_force_high | output | 1 | Drives the crystal output pin high |
| cpu_resume | output | 1 | High during the two resume cycles |
| in_stop | output | 1 | High during stop and settling |

## Verification
The assertions assume that stop_req, ext_irq and rst are synchronous to clk, and that reset is asserted at the first clock edge. The stimulus changes every input only on the falling edge and applies reset from time zero. The assertions also assume that ckctlr is steady at the edge that accepts a stop request. The bench sets the code a full cycle before it raises stop_req, and changes it only later, while the block is stopped.

// File: rtl/stopctl_pkg.sv
`timescale 1ns/1ps
package stopctl_pkg;

    localparam int CTL_W = 4;
    localparam int SEL_W = 3;
    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_STAB   = 2'd2,
        ST_RESUME = 2'd3
    } wake_state_e;

    typedef struct packed {
        logic osc_en;
        logic clk_gate_en;
        logic xin_low;
        logic xout_high;
        logic resume;
        logic in_stop;
    } pin_ctl_t;

    // Divider tap index taken from the upper bits of the prescale code.
    function automatic logic [SEL_W-1:0] tap_of(input logic [CTL_W-1:0] code);
        return SEL_W'(code >> (CTL_W - SEL_W));
    endfunction

    // Low-order ones mask: the tick fires when these divider bits are all set.
    function automatic logic [DIV_W-1:0] tap_mask(input logic [SEL_W-1:0] k);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i < int'(k));
        end
        return m;
    endfunction

    function automatic pin_ctl_t decode_pins(input wake_state_e s);
        pin_ctl_t p;
        p.osc_en      = (s != ST_STOP);
        p.clk_gate_en = (s == ST_RUN) || (s == ST_RESUME);
        p.xin_low     = (s == ST_STOP);
        p.xout_high   = (s == ST_STOP);
        p.resume      = (s == ST_RESUME);
        p.in_stop     = (s == ST_STOP) || (s == ST_STAB);
        return p;
    endfunction

endpackage

// File: rtl/stopctl_prescaler.sv
`timescale 1ns/1ps
module stopctl_prescaler
    import stopctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = tap_mask(sel);
    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R6: the divider starts every settle interval from zero
    a_r6_div_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (div_q == '0));

endmodule

// File: rtl/stopctl_settle_cnt.sv
`timescale 1ns/1ps
module stopctl_settle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic ovf
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    assign ovf = tick && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: counter restarts at zero on entry, so no early carry is possible
    a_r6_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0) && !ovf);

endmodule

// File: rtl/stopctl_fsm.sv
`timescale 1ns/1ps
module stopctl_fsm
    import stopctl_pkg::*;
#(
    parameter int RESUME_SLOTS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        ext_irq,
    input  logic        ovf,
    output wake_state_e state,
    output logic        start_stab,
    output logic        latch_sel
);

    localparam int SLOT_W = (RESUME_SLOTS > 1) ? $clog2(RESUME_SLOTS) : 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(RESUME_SLOTS - 1);

    wake_state_e      state_q, state_d;
    logic [SLOT_W-1:0] slot_q;

    assign state = state_q;

    always_comb begin
        state_d    = state_q;
        start_stab = 1'b0;
        latch_sel  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) begin
                    state_d   = ST_STOP;
                    latch_sel = 1'b1;
                end
            end
            ST_STOP: begin
                if (ext_irq) begin
                    state_d    = ST_STAB;
                    start_stab = 1'b1;
                end
            end
            ST_STAB: begin
                if (ovf) state_d = ST_RESUME;
            end
            ST_RESUME: begin
                if (slot_q == LAST) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RESUME && slot_q != LAST) begin
                slot_q <= slot_q + 1'b1;
            end else begin
                slot_q <= '0;
            end
        end
    end

    // R2: an accepted request enters stop
    a_r2_enter_stop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && stop_req) |=> (state_q == ST_STOP));
    // R3: stop is held without a wake event
    a_r3_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && !ext_irq) |=> (state_q == ST_STOP));
    // R4: an interrupt alone never moves the running block
    a_r4_irq_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !stop_req) |=> (state_q == ST_RUN));
    // R5: interrupt in stop starts settling
    a_r5_wake_to_stab: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && ext_irq) |=> (state_q == ST_STAB));
    // R8: resume is only reached by a counter overflow
    a_r8_resume_after_ovf: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME && $past(state_q) == ST_STAB) |-> $past(ovf));
    // R9: no stop entry straight out of the resume window
    a_r9_no_restop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESUME) |=> (state_q != ST_STOP));
    // R10: reset always lands in run
    a_r10_reset_to_run: assert property (@(posedge clk)
        rst |=> (state_q == ST_RUN));

endmodule

// File: rtl/stopctl_wake.sv
`timescale 1ns/1ps
module stopctl_wake
    import stopctl_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int RESUME_SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             ext_irq,
    input  logic [CTL_W-1:0] ckctlr,
    output logic             osc_en,
    output logic             clk_gate_en,
    output logic             xin_force_low,
    output logic             xout_force_high,
    output logic             cpu_resume,
    output logic             in_stop
);

    wake_state_e      state;
    logic             start_stab;
    logic             latch_sel;
    logic             tick;
    logic             ovf;
    logic [SEL_W-1:0] sel_q;
    pin_ctl_t         pins;

    stopctl_fsm #(.RESUME_SLOTS(RESUME_SLOTS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (stop_req),
        .ext_irq    (ext_irq),
        .ovf        (ovf),
        .state      (state),
        .start_stab (start_stab),
        .latch_sel  (latch_sel)
    );

    // Prescale tap captured at the stop request
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (latch_sel) begin
            sel_q <= tap_of(ckctlr);
        end
    end

    stopctl_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_stab),
        .run  (state == ST_STAB),
        .sel  (sel_q),
        .tick (tick)
    );

    stopctl_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_stab),
        .tick (tick),
        .ovf  (ovf)
    );

    assign pins            = decode_pins(state);
    assign osc_en          = pins.osc_en;
    assign clk_gate_en     = pins.clk_gate_en;
    assign xin_force_low   = pins.xin_low;
    assign xout_force_high = pins.xout_high;
    assign cpu_resume      = pins.resume;
    assign in_stop         = pins.in_stop;

    // R7: captured tap cannot change outside the run state
    a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(sel_q));

endmodule

// File: tb/stopctl_wake_test.sv
`timescale 1ns/1ps
module stopctl_wake_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 1'b0;
    logic       ext_irq = 1'b0;
    logic [3:0] ckctlr = 4'h0;
    logic       osc_en, clk_gate_en, xin_force_low, xout_force_high, cpu_resume, in_stop;

    int tests = 0;
    int fails = 0;

    // Output pack {osc_en, clk_gate_en, xin_force_low, xout_force_high, cpu_resume, in_stop}
    localparam int P_RUN    = 6'b110000;
    localparam int P_STOP   = 6'b001101;
    localparam int P_STAB   = 6'b100001;
    localparam int P_RESUME = 6'b110010;

    // Vector table: prescale code and expected edges to clock release (256*2^k+1)
    localparam int NV = 8;
    localparam logic [3:0] VEC_CK  [NV] = '{4'h0, 4'h3, 4'h5, 4'h6, 4'h9, 4'hB, 4'hE, 4'hF};
    localparam int         VEC_EXP [NV] = '{257, 513, 1025, 2049, 4097, 8193, 32769, 32769};

    always #2.5 clk = ~clk;

    stopctl_wake uut (
        .clk             (clk),
        .rst             (rst),
        .stop_req        (stop_req),
        .ext_irq         (ext_irq),
        .ckctlr          (ckctlr),
        .osc_en          (osc_en),
        .clk_gate_en     (clk_gate_en),
        .xin_force_low   (xin_force_low),
        .xout_force_high (xout_force_high),
        .cpu_resume      (cpu_resume),
        .in_stop         (in_stop)
    );

    function automatic int pins();
        return {26'd0, osc_en, clk_gate_en, xin_force_low, xout_force_high, cpu_resume, in_stop};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_stop(input logic [3:0] code);
        ckctlr = code;
        step(1);
        stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
    endtask

    // Wake from stop; returns edges until clk_gate_en rises
    task automatic wake_and_measure(output int edges);
        ext_irq = 1'b1;
        step(1);
        ext_irq = 1'b0;
        check("R5", pins(), P_STAB);
        edges = 1;
        while (!clk_gate_en) begin
            step(1);
            edges++;
        end
    endtask

    task automatic finish_resume();
        check("R8", pins(), P_RESUME);
        step(1);
        check("R8", pins(), P_RESUME);
        step(1);
        check("R8", pins(), P_RUN);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int edges;
        int bad;
        step(1);
        check("R1", pins(), P_RUN);
        step(2);
        rst = 1'b0;
        step(1);
        check("R1", pins(), P_RUN);

        // R4: interrupt while running
        ext_irq = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R4", pins(), P_RUN);
        end
        ext_irq = 1'b0;

        // Vector table walk: R2, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            do_stop(VEC_CK[i]);
            check("R2", pins(), P_STOP);
            if (i == 6) ckctlr = 4'h0;
            step(3);
            check("R3", pins(), P_STOP);
            wake_and_measure(edges);
            check((i == 6) ? "R7" : "R6", edges, VEC_EXP[i]);
            finish_resume();
        end

        // R3: long stop with request toggling and code changes
        do_stop(4'h0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            stop_req = ~stop_req;
            ckctlr = 4'(i);
            step(1);
            if (pins() != P_STOP) bad++;
        end
        stop_req = 1'b0;
        check("R3", bad, 0);
        wake_and_measure(edges);
        check("R3", edges, 257);
        finish_resume();

        // R9: stop request across the resume window
        do_stop(4'h0);
        wake_and_measure(edges);
        stop_req = 1'b1;
        step(1);
        check("R9", pins(), P_RESUME);
        step(1);
        stop_req = 1'b0;
        check("R9", pins(), P_RUN);
        step(2);
        check("R9", pins(), P_RUN);

        // R10: reset in stop
        do_stop(4'h2);
        step(5);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check("R10", pins(), P_RUN);

        // R10: reset in settling, no resume afterwards
        do_stop(4'h0);
        ext_irq = 1'b1;
        step(1);
        ext_irq = 1'b0;
        step(20);
        check("R10", pins(), P_STAB);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check("R10", pins(), P_RUN);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (cpu_resume || in_stop) bad++;
        end
        check("R10", bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule